// File: doc/BRIEF.md
# Serial Flash Power-Down Release and Signature Responder

This block is the slave-side logic of a serial flash device that deals with power states. It watches a four-wire SPI slave bus and decodes the release command (opcode 0xAB). That command takes the device out of deep power-down, and it also answers with an 8-bit device signature. A small stub decoder recognises one other opcode, the deep power-down entry command (0xB9). A busy input marks an erase, program or status-register write in progress. A request input lets the rest of the chip put the device into deep power-down directly.

All serial pins are brought into the system clock domain through two-stage synchronisers. Edges of select and serial clock are then detected there. For this reason the serial clock must run well below the system clock: each serial half-period has to cover at least four system clocks. Leaving deep power-down passes through a waking state that lasts a set number of system clocks. During that time the device reports itself not ready and ignores any transaction that begins.

Top module: `flash_pd_sig`

## Requirements
- R1: After reset the power mode reads 00 (standby), ready is high and the data output enable is low.
- R2: A command is an opcode byte followed by DUMMY_BYTES (default 3) dummy bytes, each bit sampled on a rising serial clock edge. The data output enable stays low during these header bytes and whenever select is high.
- R3: After a decoded release command, the signature (default 0x05) is driven MSB first. Each bit changes on a falling serial clock edge, and the first bit appears on the fall that follows the last header bit.
- R4: While select stays low and the clock keeps running, the signature repeats with no gap bits.
- R5: A release command issued in standby still returns the signature. On select rising, the mode stays 00 and ready stays high.
- R6: A complete 0xB9 opcode in standby, followed by select rising, moves the mode to 01 (deep power-down).
- R7: In deep power-down, every opcode other than 0xAB is ignored: no output is driven and the mode stays 01.
- R8: A release command in deep power-down moves the mode to 10 (waking) with ready low once select rises. This holds even if select rises right after the opcode byte, before any signature bit has been sent.
- R9: The waking state lasts WAKE_CYCLES system clocks and then returns to 00. A transaction whose select falls during waking is ignored entirely, even if waking ends partway through it.
- R10: While busy is high, the release command is not decoded: no signature is sent and the mode does not change. In standby with busy high, the mode reads 11.
- R11: If select rises before all 8 opcode bits have arrived, the command is aborted and the state is unchanged. The next transaction is decoded from its first bit.
- R12: A pulse on the power-down request input, taken while in standby with select idle high and busy low, moves the mode to 01. The pulse is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low means high-impedance) |
| busy_i | input | 1 | Erase, program or status write in progress |
| dpd_req | input | 1 | Request to enter deep power-down |
| pwr_mode | output | 2 | 00 standby, 01 deep power-down, 10 waking, 11 busy |
| ready | output | 1 | High unless waking |

## Verification
The bench attacks the boundaries of the signature stream. It reads two back-to-back signature bytes, which exposes a design that inserts a gap bit or restarts late. It also checks that no enable leaks during the header, which a design that counts the dummy bytes wrong would show. In deep power-down it sends foreign opcodes and aborts the release opcode after seven bits; a decoder that is too permissive would leave the mode early. It measures the waking length and starts a power-down command during waking, so a design that does not latch the ignore decision at select falling would fall back into deep power-down. Busy is held high both in standby and in deep power-down, where a design that decodes anyway would answer or wake.

// File: rtl/flash_pd_sig.sv
module flash_pd_sig #(
  parameter logic [7:0] SIG = 8'h05,
  parameter logic [7:0] OP_REL = 8'hAB,
  parameter logic [7:0] OP_PD = 8'hB9,
  parameter int DUMMY_BYTES = 3,
  parameter int WAKE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic       busy_i,
  input  logic       dpd_req,
  output logic [1:0] pwr_mode,
  output logic       ready
);
  localparam int HDR = 8 * (DUMMY_BYTES + 1);
  localparam int CW = $clog2(HDR + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [1:0] M_STBY = 2'd0, M_DPD = 2'd1, M_WAKE = 2'd2, M_BUSY = 2'd3;

  logic [2:0] cs_p, sck_p;
  logic [1:0] mosi_p;
  logic [1:0] st;
  logic [WW-1:0] wake_cnt;
  logic [CW-1:0] bit_cnt;
  logic [6:0] op_sh;
  logic [7:0] op_full;
  logic sel_ok, rel_hit, pd_hit, out_on;
  logic [2:0] out_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= 3'b111;
      sck_p <= 3'b000;
      mosi_p <= 2'b00;
    end else begin
      cs_p <= {cs_p[1:0], spi_cs_n};
      sck_p <= {sck_p[1:0], spi_sck};
      mosi_p <= {mosi_p[0], spi_mosi};
    end

  wire cs_idle  = cs_p[1] & cs_p[2];
  wire cs_fall  = !cs_p[1] & cs_p[2];
  wire cs_rise  = cs_p[1] & !cs_p[2];
  wire sel      = !cs_p[1] & !cs_p[2];
  wire sck_rise = sel & sck_p[1] & !sck_p[2];
  wire sck_fall = sel & !sck_p[1] & sck_p[2];
  wire hdr_done = bit_cnt == CW'(HDR);
  assign op_full = {op_sh, mosi_p[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      op_sh <= '0;
      sel_ok <= 1'b0;
      rel_hit <= 1'b0;
      pd_hit <= 1'b0;
      out_on <= 1'b0;
      out_idx <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      rel_hit <= 1'b0;
      pd_hit <= 1'b0;
      out_on <= 1'b0;
      out_idx <= '0;
      sel_ok <= st != M_WAKE;
    end else if (cs_rise) begin
      out_on <= 1'b0;
    end else begin
      if (sck_rise && !hdr_done) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < CW'(7)) op_sh <= {op_sh[5:0], mosi_p[1]};
        if (bit_cnt == CW'(7) && sel_ok && !busy_i) begin
          rel_hit <= op_full == OP_REL;
          pd_hit <= (op_full == OP_PD) && (st == M_STBY);
        end
      end
      if (sck_fall && rel_hit && hdr_done) begin
        if (out_on) out_idx <= out_idx + 1'b1;
        else begin
          out_on <= 1'b1;
          out_idx <= '0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= M_STBY;
      wake_cnt <= '0;
    end else if (st == M_WAKE) begin
      if (wake_cnt == '0) st <= M_STBY;
      else wake_cnt <= wake_cnt - 1'b1;
    end else if (cs_rise && rel_hit && st == M_DPD) begin
      st <= M_WAKE;
      wake_cnt <= WW'(WAKE_CYCLES - 1);
    end else if (cs_rise && pd_hit && st == M_STBY) begin
      st <= M_DPD;
    end else if (dpd_req && cs_idle && !busy_i && st == M_STBY) begin
      st <= M_DPD;
    end

  assign spi_miso_oe = out_on;
  assign spi_miso = out_on & SIG[~out_idx];
  assign pwr_mode = (st == M_STBY && busy_i) ? M_BUSY : st;
  assign ready = st != M_WAKE;

  // R2
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_idle |-> !out_on);
  // R2
  oe_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n) out_on |-> hdr_done);
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall) |=> $stable(out_idx));
  // R7
  dpd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_DPD && !cs_rise) |=> st == M_DPD);
  // R9
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_WAKE) |=> (st == M_WAKE || st == M_STBY));
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt < CW'(8) && st != M_WAKE) |=> $stable(st));
endmodule

// File: tb/tb_flash_pd_sig.sv
`timescale 1ns/1ps
module tb_flash_pd_sig;
  localparam int WAKE = 400;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, busy = 0, dpd_req = 0;
  logic miso, oe, ready;
  logic [1:0] mode;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [8:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  flash_pd_sig #(.WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .busy_i(busy), .dpd_req(dpd_req),
    .pwr_mode(mode), .ready(ready));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic shift_byte(input logic [7:0] tx, input int nbits, output logic [8:0] got);
    logic [7:0] b;
    logic any;
    b = '0;
    any = 1'b0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      tick(HALF);
      any |= oe;
      b[i] = miso & oe;
      sck = 1;
      tick(HALF);
      sck = 0;
    end
    got = {any, b};
  endtask

  task automatic xfer(input logic [7:0] op, input int nsig, input bit sig_ok, input string r);
    logic [8:0] g;
    cs_n = 0;
    tick(HALF);
    exp_q.push_back(9'h000); tag_q.push_back("R2 opcode");
    shift_byte(op, 8, g); got_q.push_back(g);
    for (int d = 0; d < 3; d++) begin
      exp_q.push_back(9'h000); tag_q.push_back("R2 dummy");
      shift_byte(8'h00, 8, g); got_q.push_back(g);
    end
    for (int s = 0; s < nsig; s++) begin
      exp_q.push_back(sig_ok ? 9'h105 : 9'h000); tag_q.push_back(r);
      shift_byte(8'h00, 8, g); got_q.push_back(g);
    end
    tick(HALF);
    cs_n = 1;
    tick(12);
    check("R2 oe idle", int'(oe), 0);
  endtask

  task automatic partial(input logic [7:0] op, input int nbits);
    logic [8:0] g;
    cs_n = 0;
    tick(HALF);
    shift_byte(op, nbits, g);
    tick(HALF);
    cs_n = 1;
    tick(12);
  endtask

  task automatic wait_awake();
    int c = 0;
    while (mode == 2'd2 && c < 5000) begin tick(1); c++; end
    check("R9 awake", int'(mode), 0);
  endtask

  always @(negedge clk) begin
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [8:0] e, g;
      string t;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h", t, g[8], g[7:0], e[8], e[7:0]);
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    tick(5);
    rst_n = 1;
    tick(5);
    // R1
    check("R1 mode", int'(mode), 0);
    check("R1 ready", int'(ready), 1);
    check("R1 oe", int'(oe), 0);

    // R3 R4: two signature bytes back to back from standby
    xfer(8'hAB, 2, 1, "R3 R4 signature");
    // R5
    check("R5 mode", int'(mode), 0);
    check("R5 ready", int'(ready), 1);
    xfer(8'hAB, 1, 1, "R5 signature");

    // R6
    xfer(8'hB9, 0, 0, "R6");
    check("R6 mode", int'(mode), 1);

    // R7
    xfer(8'h9F, 1, 0, "R7 foreign op");
    check("R7 mode", int'(mode), 1);
    xfer(8'hB9, 1, 0, "R7 repeat entry");
    check("R7 mode", int'(mode), 1);

    // R8: release in deep power-down returns signature and starts waking
    xfer(8'hAB, 1, 1, "R8 signature");
    check("R8 mode", int'(mode), 2);
    check("R8 ready", int'(ready), 0);
    c = 0;
    while (mode == 2'd2 && c < 5000) begin tick(1); c++; end
    // R9: waking length
    n_cmp++;
    if (c < WAKE - 11 || c > WAKE - 7) begin
      n_bad++;
      $display("FAIL R9 wake length: actual %0d expected %0d", c, WAKE - 9);
    end
    check("R9 mode", int'(mode), 0);

    // R8: select rises right after opcode
    xfer(8'hB9, 0, 0, "R6");
    check("R6 mode", int'(mode), 1);
    partial(8'hAB, 8);
    check("R8 early rise", int'(mode), 2);
    // R9: entry command during waking is ignored
    xfer(8'hB9, 0, 0, "R9");
    check("R9 ignored entry", int'(mode), 0);

    xfer(8'hB9, 0, 0, "R6");
    partial(8'hAB, 8);
    check("R8 early rise", int'(mode), 2);
    xfer(8'hAB, 1, 0, "R9 release during waking");
    check("R9 mode", int'(mode), 0);

    // R10
    busy = 1;
    tick(2);
    check("R10 busy mode", int'(mode), 3);
    xfer(8'hAB, 1, 0, "R10 busy release");
    check("R10 busy mode", int'(mode), 3);
    busy = 0;
    tick(2);
    check("R10 mode", int'(mode), 0);
    xfer(8'hB9, 0, 0, "R6");
    busy = 1;
    xfer(8'hAB, 1, 0, "R10 busy in dpd");
    check("R10 dpd kept", int'(mode), 1);
    busy = 0;

    // R11
    partial(8'hAB, 7);
    check("R11 dpd abort", int'(mode), 1);
    xfer(8'hAB, 1, 1, "R8 signature");
    wait_awake();
    partial(8'hB9, 5);
    check("R11 abort", int'(mode), 0);
    xfer(8'hAB, 1, 1, "R11 next decode");

    // R12
    busy = 1;
    dpd_req = 1; tick(1); dpd_req = 0;
    tick(4);
    check("R12 busy ignore", int'(mode), 3);
    busy = 0;
    tick(2);
    check("R12 mode", int'(mode), 0);
    dpd_req = 1; tick(1); dpd_req = 0;
    tick(4);
    check("R12 entry", int'(mode), 1);
    xfer(8'hAB, 1, 1, "R8 signature");
    wait_awake();

    tick(20);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule